// File: doc/BRIEF.md
# Interlaced Field Sync Selector

This block takes a digitized, active-low composite sync from an interlaced camera and turns it into one vertical-retrace indication per complete image. A raw interlaced source produces a vertical sync once per field, so twice per image. The block reports each of these on its own output. It then passes only the retrace of one chosen field on a second output.

Vertical sync is recognised by timing the low portions of the sync signal. A low run that lasts at least a programmable number of clocks counts as vertical sync. Shorter pulses are treated as horizontal sync. The block also times the spacing between successive sync falling edges. The spacing that leads into the vertical pulse tells the two fields apart: a half line means the field that just ended was odd, and a full line means it was even.

A parity flag records that result. When the measured spacing fits neither window, the flag simply toggles, so the parity keeps alternating and is pulled back into phase by the next clean measurement. A static select input plays the role of a jumper and chooses which field's retrace reaches the frame output. The sync pin is asynchronous and passes through a two-flop synchronizer before any counting.

Top module: `interlace_frame_sync`

## Requirements
- R1: While reset is held and in the first cycle after its release, `vsync_n` and `frame_retrace_n` are 1 and `field_odd` is 0.
- R2: Suppose `csync_n` is low for N consecutive rising clock edges, with N >= VS_THRESH. Then `vsync_n` falls after the (VS_THRESH+2)-th of those edges. The two extra edges come from the synchronizer.
- R3: A low run shorter than VS_THRESH edges leaves `vsync_n` and `frame_retrace_n` high and leaves `field_odd` unchanged.
- R4: `vsync_n` returns high after the third rising edge that samples `csync_n` high again. A qualifying low run of N edges therefore gives a `vsync_n` low time of N+1-VS_THRESH cycles.
- R5: Call the count of clocks between the sync falling edge before the vertical pulse and the falling edge of the vertical pulse the last-line length. If it lies in [HALF_MIN, HALF_MAX], `field_odd` becomes 1 at the edge where `vsync_n` falls. If it lies in [FULL_MIN, FULL_MAX], `field_odd` becomes 0 at that edge.
- R6: If the last-line length lies in neither window, `field_odd` inverts at the edge where `vsync_n` falls.
- R7: The select input works as follows. With `sel_even` = 0, `frame_retrace_n` is low exactly when `vsync_n` is low and `field_odd` is 1. With `sel_even` = 1, it is low exactly when `vsync_n` is low and `field_odd` is 0.
- R8: When fields alternate between half-line and full-line endings, `frame_retrace_n` pulses once for every two `vsync_n` pulses.
- R9: `field_odd` changes only in the cycle in which `vsync_n` falls. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Composite sync, active low, asynchronous to clk |
| sel_even | input | 1 | Field select: 0 passes the odd field's retrace, 1 the even field's |
| vsync_n | output | 1 | Per-field vertical sync, low during each retrace |
| field_odd | output | 1 | 1 when the field that last ended was odd |
| frame_retrace_n | output | 1 | Low during the selected field's retrace only |

## Verification
The assertions assume that `csync_n` is driven synchronously enough that each level is held for whole clock periods. They also assume that `sel_even` changes only while no retrace is in progress. The bench meets both conditions: it changes the pin and the select only on falling clock edges, and it sets the select before each field's line pulse. The assertions also assume that no low run is long enough to saturate the counters. The bench keeps every pulse and line length well under the counter range.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
   typedef enum logic [1:0] {
      LEN_HALF  = 2'd0,
      LEN_FULL  = 2'd1,
      LEN_OTHER = 2'd2
   } len_class_e;
endpackage

// File: rtl/fsync_sync.sv
module fsync_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fsync_meter.sv
module fsync_meter #(
   parameter int CNT_W     = 8,
   parameter int VS_THRESH = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_n,
   output logic             vs_hit,
   output logic             vs_on,
   output logic [CNT_W-1:0] last_len
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] HIT_AT  = CNT_W'(VS_THRESH - 1);

   logic [CNT_W-1:0] low_cnt;
   logic [CNT_W-1:0] per_cnt;
   logic             fall;

   assign fall   = !sync_n && (low_cnt == '0);
   assign vs_hit = !sync_n && (low_cnt == HIT_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         per_cnt  <= '0;
         last_len <= '0;
         vs_on    <= 1'b0;
      end else begin
         if (sync_n)                  low_cnt <= '0;
         else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;

         if (fall) begin
            last_len <= per_cnt;
            per_cnt  <= CNT_W'(1);
         end else if (per_cnt != CNT_MAX) begin
            per_cnt  <= per_cnt + 1'b1;
         end

         if (sync_n)      vs_on <= 1'b0;
         else if (vs_hit) vs_on <= 1'b1;
      end
   end
endmodule

// File: rtl/fsync_field.sv
module fsync_field
   import fsync_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int HALF_MIN = 24,
   parameter int HALF_MAX = 40,
   parameter int FULL_MIN = 56,
   parameter int FULL_MAX = 72,
   parameter bit RESYNC   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vs_hit,
   input  logic [CNT_W-1:0] last_len,
   output logic             field_odd
);
   len_class_e cls;
   logic       next_odd;

   always_comb begin
      if (last_len >= CNT_W'(HALF_MIN) && last_len <= CNT_W'(HALF_MAX))
         cls = LEN_HALF;
      else if (last_len >= CNT_W'(FULL_MIN) && last_len <= CNT_W'(FULL_MAX))
         cls = LEN_FULL;
      else
         cls = LEN_OTHER;
   end

   if (RESYNC) begin : g_resync
      always_comb begin
         case (cls)
            LEN_HALF: next_odd = 1'b1;
            LEN_FULL: next_odd = 1'b0;
            default:  next_odd = ~field_odd;
         endcase
      end
   end else begin : g_toggle
      always_comb next_odd = ~field_odd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      field_odd <= 1'b0;
      else if (vs_hit) field_odd <= next_odd;
   end
endmodule

// File: rtl/interlace_frame_sync.sv
module interlace_frame_sync #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VS_THRESH   = 20,
   parameter int HALF_MIN    = 24,
   parameter int HALF_MAX    = 40,
   parameter int FULL_MIN    = 56,
   parameter int FULL_MAX    = 72,
   parameter bit RESYNC      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csync_n,
   input  logic sel_even,
   output logic vsync_n,
   output logic field_odd,
   output logic frame_retrace_n
);
   localparam int CNT_LIMIT = (1 << CNT_W) - 1;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (VS_THRESH < 2 || VS_THRESH > CNT_LIMIT) begin : g_chk_thr
      $error("VS_THRESH out of range");
   end
   if (!(HALF_MIN <= HALF_MAX && HALF_MAX < FULL_MIN && FULL_MIN <= FULL_MAX)) begin : g_chk_win
      $error("line windows must be ordered and disjoint");
   end
   if (FULL_MAX >= CNT_LIMIT) begin : g_chk_cnt
      $error("CNT_W too narrow for FULL_MAX");
   end

   logic             sync_s;
   logic             vs_hit;
   logic             vs_on;
   logic [CNT_W-1:0] last_len;

   fsync_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (csync_n),
      .q     (sync_s)
   );

   fsync_meter #(.CNT_W(CNT_W), .VS_THRESH(VS_THRESH)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_n   (sync_s),
      .vs_hit   (vs_hit),
      .vs_on    (vs_on),
      .last_len (last_len)
   );

   fsync_field #(
      .CNT_W    (CNT_W),
      .HALF_MIN (HALF_MIN),
      .HALF_MAX (HALF_MAX),
      .FULL_MIN (FULL_MIN),
      .FULL_MAX (FULL_MAX),
      .RESYNC   (RESYNC)
   ) u_field (
      .clk       (clk),
      .rst_n     (rst_n),
      .vs_hit    (vs_hit),
      .last_len  (last_len),
      .field_odd (field_odd)
   );

   assign vsync_n         = ~vs_on;
   assign frame_retrace_n = ~(vs_on & (field_odd ^ sel_even));
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker (
   input logic clk,
   input logic rst_n,
   input logic csync_n,
   input logic sel_even,
   input logic vsync_n,
   input logic field_odd,
   input logic frame_retrace_n
);
   // R2: a retrace starts only after the pin has been low long enough
   a_r2_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vsync_n) |-> (!$past(csync_n, 3) && !$past(csync_n, 4)));

   // R4: the pin high three edges ago forces the retrace off
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csync_n, 3) |-> vsync_n);

   // R7: the frame output is only ever a selected-field retrace
   a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_retrace_n |-> (!vsync_n && (field_odd == !sel_even)));

   // R9: parity moves only where a retrace begins
   a_r9_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(vsync_n) |-> $stable(field_odd));
endmodule

bind interlace_frame_sync fsync_checker u_chk (.*);

// File: tb/interlace_frame_sync_test.sv
module interlace_frame_sync_test;
   localparam time CLK_PERIOD = 10ns;
   localparam int  THR        = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csync_n = 1'b1;
   logic sel_even = 1'b0;
   logic vsync_n, field_odd, frame_retrace_n;

   int checks = 0;
   int errors = 0;
   int vs_lows, fr_lows, fr_pulses, vs_pulses;
   logic fr_prev, vs_prev;

   always #(CLK_PERIOD/2) clk = ~clk;

   interlace_frame_sync uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .csync_n         (csync_n),
      .sel_even        (sel_even),
      .vsync_n         (vsync_n),
      .field_odd       (field_odd),
      .frame_retrace_n (frame_retrace_n)
   );

   typedef struct packed {
      int unsigned p;
      int unsigned n;
      bit          sel;
      bit          exp_odd;
   } vec_t;

   // last-line length, vertical low width, select, expected parity
   localparam vec_t VECS [11] = '{
      '{32, 30, 1'b0, 1'b1},   // R5 half line
      '{64, 30, 1'b0, 1'b0},   // R5 full line
      '{32, 20, 1'b0, 1'b1},   // R2 exact threshold
      '{64, 19, 1'b0, 1'b1},   // R3 one short: parity held
      '{64, 25, 1'b1, 1'b0},   // R7 even selected
      '{48, 25, 1'b1, 1'b1},   // R6 between windows: toggle
      '{100, 25, 1'b0, 1'b0},  // R6 beyond windows: toggle
      '{24, 22, 1'b0, 1'b1},   // R5 half window low edge
      '{72, 22, 1'b1, 1'b0},   // R5 full window high edge
      '{41, 22, 1'b0, 1'b1},   // R6 just above half window
      '{55, 22, 1'b1, 1'b0}    // R6 just below full window
   };

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic drive(input logic level, input int unsigned cycles);
      for (int unsigned i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (!vsync_n) vs_lows++;
         if (!frame_retrace_n) fr_lows++;
         if (vs_prev && !vsync_n) vs_pulses++;
         if (fr_prev && !frame_retrace_n) fr_pulses++;
         vs_prev = vsync_n;
         fr_prev = frame_retrace_n;
         csync_n = level;
      end
   endtask

   task automatic field(input int unsigned p, input int unsigned n);
      drive(1'b0, 4);
      drive(1'b1, p - 4);
      drive(1'b0, n);
      drive(1'b1, 8);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      vs_prev = 1'b1;
      fr_prev = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 vsync_n in reset", int'(vsync_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 vsync_n", int'(vsync_n), 1);
      check("R1 frame_retrace_n", int'(frame_retrace_n), 1);
      check("R1 field_odd", int'(field_odd), 0);

      foreach (VECS[k]) begin
         int exp_vs;
         int exp_fr;
         sel_even = VECS[k].sel;
         vs_lows = 0;
         fr_lows = 0;
         field(VECS[k].p, VECS[k].n);
         exp_vs = (VECS[k].n >= THR) ? int'(VECS[k].n) + 1 - THR : 0;
         exp_fr = (VECS[k].exp_odd != VECS[k].sel) ? exp_vs : 0;
         check($sformatf("R2 R3 R4 vsync width vec%0d", k), vs_lows, exp_vs);
         check($sformatf("R7 frame width vec%0d", k), fr_lows, exp_fr);
         check($sformatf("R5 R6 R9 parity vec%0d", k), int'(field_odd), int'(VECS[k].exp_odd));
      end

      // R8: alternating half/full fields give one frame pulse per two fields
      sel_even = 1'b0;
      vs_pulses = 0;
      fr_pulses = 0;
      field(32, 25);
      field(64, 25);
      field(32, 25);
      field(64, 25);
      check("R8 vsync pulses", vs_pulses, 4);
      check("R8 frame pulses", fr_pulses, 2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule